// File: doc/BRIEF.md
# Serial Register Loader for a Fractional-N Synthesizer

This block is the write-only programming port of a fractional-N frequency synthesizer. A host drives three plain wires: a serial clock, a serial data line and a load strobe. The block brings all three into the system clock domain through synchronisers and finds their edges. On every rising edge of the serial clock it shifts in one data bit into a 24-bit word, most significant bit first. On a rising edge of the load strobe it decodes the two lowest bits of that word and copies the word's fields into one of four internal registers: integer/fraction divider, reference divider, control, or noise/spur mode. The decoded fields are driven out as parallel buses.

Two behaviours go beyond a plain register file. First, the fractional modulus is double-buffered. A reference-divider write only stages a new modulus. The staged value reaches the modulus output when the integer/fraction register is next written, so that integer, fraction and modulus change together. Second, a load-control bit in the reference-divider word sends the 12-bit modulus field to a separate resync-delay register instead. In that case the staged modulus, the active modulus and the other reference-divider fields are left as they were. Every integer/fraction write also raises a one-cycle channel-change strobe, for use by the lock-detect and resync logic.

The serial input has no ready line and no back-pressure. Each word is accepted when the load strobe rises, and the decoded outputs are plain levels. Each serial clock phase and each load-strobe phase must stay stable for at least three system clock cycles.

Top module: `synth_serial_regs`

## Requirements
- R1: Each rising edge of `ser_clk` shifts `ser_data` into the word, MSB first. When more than 24 bits are sent before a load, only the last 24 bits count.
- R2: On a rising edge of `ser_le`, word bits [1:0] pick the destination: 00 integer/fraction, 01 reference divider, 10 control, 11 noise/spur. The other three registers are unchanged.
- R3: Integer/fraction word: bit 23 sets `fastlock`, bits [22:14] set `n_int` and bits [13:2] set `n_frac`.
- R4: Reference-divider word with bit 23 = 0: bits [22:20] set `mux_sel`, bit 19 sets `presc_sel` and bits [17:14] set `ref_count`. Bits [13:2] set the staged modulus.
- R5: `mod_active` takes the staged modulus only on the next integer/fraction write. A reference-divider write by itself leaves `mod_active` unchanged.
- R6: Reference-divider word with bit 23 = 1: bits [13:2] set `resync_delay`. The staged modulus, `mod_active`, `ref_count`, `mux_sel` and `presc_sel` are unchanged.
- R7: Control word: bit 3 sets `ctr_reset`, bit 4 `pwr_down`, bit 6 `pd_polarity`, bits [9:7] `cp_code` and bits [13:10] `resync_mult`.
- R8: Noise/spur word: bits [3:2] set `ns_mode`.
- R9: Each integer/fraction write raises `chan_strobe` for exactly one cycle. Writes to the other registers do not raise it.
- R10: With `pwr_down` = 1, all stored fields are kept and new words are still shifted and loaded.
- R11: An active-low asynchronous `rst_n` clears every output to zero.
- R12: Shifting bits without a rising edge of `ser_le` changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock, asynchronous |
| ser_data | input | 1 | Serial data, asynchronous |
| ser_le | input | 1 | Load strobe, asynchronous |
| n_int | output | 9 | Integer divide value |
| n_frac | output | 12 | Fractional numerator |
| fastlock | output | 1 | Force maximum pump current |
| ref_count | output | 4 | Reference divide count |
| mod_active | output | 12 | Active fractional modulus |
| mux_sel | output | 3 | Test output select |
| presc_sel | output | 1 | Prescaler select |
| resync_delay | output | 12 | Resync delay count |
| ctr_reset | output | 1 | Hold counters in reset |
| pwr_down | output | 1 | Power-down request |
| pd_polarity | output | 1 | Phase detector polarity |
| cp_code | output | 3 | Charge-pump current code |
| resync_mult | output | 4 | Resync delay multiplier |
| ns_mode | output | 2 | Noise/spur mode |
| chan_strobe | output | 1 | One-cycle channel-change pulse |

## Verification
The assertions check on every cycle that the following hold:
- a shifted bit lands in the word's LSB one cycle after the serial clock edge;
- the channel strobe never lasts two cycles;
- the active modulus changes only together with that strobe, and then takes the staged value;
- a load-control write never disturbs the staged modulus.

Only the bench's scenarios can show the following, because each needs a whole serial word and knowledge of its contents:
- the field positions of each register;
- the four-way routing;
- the drop of surplus leading bits;
- retention of contents across power-down.

// File: rtl/synth_reg_pkg.sv
package synth_reg_pkg;
  localparam int WORD_W  = 24;
  localparam int INT_W   = 9;
  localparam int FRAC_W  = 12;
  localparam int REFC_W  = 4;
  localparam int MUX_W   = 3;
  localparam int CP_W    = 3;
  localparam int MULT_W  = 4;
  localparam int NS_W    = 2;

  typedef enum logic [1:0] {
    DST_NDIV = 2'b00,
    DST_RDIV = 2'b01,
    DST_CTRL = 2'b10,
    DST_NSPR = 2'b11
  } dest_e;
endpackage

// File: rtl/edge_sync.sv
module edge_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= '0;
        else if (i == 0) stg[i] <= async_in;
        else stg[i] <= stg[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign sync_out = stg[STAGES-1];
endmodule

// File: rtl/serial_shifter.sv
module serial_shifter
  import synth_reg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              sdata_s,
  input  logic              le_s,
  output logic [WORD_W-1:0] word,
  output logic              load
);
  logic sclk_q, le_q;
  logic sclk_rise;

  assign sclk_rise = sclk_s & ~sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      le_q   <= 1'b0;
      word   <= '0;
      load   <= 1'b0;
    end else begin
      sclk_q <= sclk_s;
      le_q   <= le_s;
      load   <= le_s & ~le_q;
      if (sclk_rise) word <= {word[WORD_W-2:0], sdata_s};
    end
  end

  // R1: the sampled bit enters at the LSB one cycle after the clock edge
  assert_shift_lsb_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_rise |=> (word[0] == $past(sdata_s)));
endmodule

// File: rtl/reg_bank.sv
module reg_bank
  import synth_reg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] word,
  output logic [INT_W-1:0]  n_int,
  output logic [FRAC_W-1:0] n_frac,
  output logic              fastlock,
  output logic [REFC_W-1:0] ref_count,
  output logic [FRAC_W-1:0] mod_active,
  output logic [MUX_W-1:0]  mux_sel,
  output logic              presc_sel,
  output logic [FRAC_W-1:0] resync_delay,
  output logic              ctr_reset,
  output logic              pwr_down,
  output logic              pd_polarity,
  output logic [CP_W-1:0]   cp_code,
  output logic [MULT_W-1:0] resync_mult,
  output logic [NS_W-1:0]   ns_mode,
  output logic              chan_strobe
);
  localparam int FLD_LO = 2;
  localparam int FLD_HI = FLD_LO + FRAC_W - 1;

  dest_e             dst;
  logic              wr_n, wr_r, wr_c, wr_s, ld_ctl;
  logic [FRAC_W-1:0] mod_staged;
  logic [FRAC_W-1:0] fld12;

  assign dst    = dest_e'(word[1:0]);
  assign wr_n   = load && (dst == DST_NDIV);
  assign wr_r   = load && (dst == DST_RDIV);
  assign wr_c   = load && (dst == DST_CTRL);
  assign wr_s   = load && (dst == DST_NSPR);
  assign ld_ctl = word[WORD_W-1];
  assign fld12  = word[FLD_HI:FLD_LO];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_int <= '0; n_frac <= '0; fastlock <= 1'b0;
      mod_active <= '0; chan_strobe <= 1'b0;
    end else begin
      chan_strobe <= wr_n;
      if (wr_n) begin
        fastlock   <= word[23];
        n_int      <= word[22:14];
        n_frac     <= fld12;
        mod_active <= mod_staged;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_count <= '0; mod_staged <= '0; mux_sel <= '0;
      presc_sel <= 1'b0; resync_delay <= '0;
    end else if (wr_r) begin
      if (ld_ctl) begin
        resync_delay <= fld12;
      end else begin
        mux_sel    <= word[22:20];
        presc_sel  <= word[19];
        ref_count  <= word[17:14];
        mod_staged <= fld12;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctr_reset <= 1'b0; pwr_down <= 1'b0; pd_polarity <= 1'b0;
      cp_code <= '0; resync_mult <= '0; ns_mode <= '0;
    end else begin
      if (wr_c) begin
        ctr_reset   <= word[3];
        pwr_down    <= word[4];
        pd_polarity <= word[6];
        cp_code     <= word[9:7];
        resync_mult <= word[13:10];
      end
      if (wr_s) ns_mode <= word[3:2];
    end
  end

  // R9: the channel strobe lasts one cycle
  assert_strobe_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    chan_strobe |=> !chan_strobe);

  // R5: the active modulus moves only alongside the channel strobe
  assert_mod_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_strobe |-> $stable(mod_active));

  // R5: an integer/fraction write promotes the staged modulus
  assert_mod_promote_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_n |=> (mod_active == $past(mod_staged)));

  // R6: a load-control write leaves the staged modulus alone
  assert_ldctl_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_r && ld_ctl) |=> $stable(mod_staged));
endmodule

// File: rtl/synth_serial_regs.sv
module synth_serial_regs
  import synth_reg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_data,
  input  logic              ser_le,
  output logic [8:0]        n_int,
  output logic [11:0]       n_frac,
  output logic              fastlock,
  output logic [3:0]        ref_count,
  output logic [11:0]       mod_active,
  output logic [2:0]        mux_sel,
  output logic              presc_sel,
  output logic [11:0]       resync_delay,
  output logic              ctr_reset,
  output logic              pwr_down,
  output logic              pd_polarity,
  output logic [2:0]        cp_code,
  output logic [3:0]        resync_mult,
  output logic [1:0]        ns_mode,
  output logic              chan_strobe
);
  logic [2:0]        pins_s;
  logic [WORD_W-1:0] word;
  logic              load;

  edge_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .async_in({ser_le, ser_clk, ser_data}),
    .sync_out(pins_s)
  );

  serial_shifter u_shift (
    .clk(clk), .rst_n(rst_n),
    .sclk_s(pins_s[1]), .sdata_s(pins_s[0]), .le_s(pins_s[2]),
    .word(word), .load(load)
  );

  reg_bank u_bank (
    .clk(clk), .rst_n(rst_n), .load(load), .word(word),
    .n_int(n_int), .n_frac(n_frac), .fastlock(fastlock),
    .ref_count(ref_count), .mod_active(mod_active), .mux_sel(mux_sel),
    .presc_sel(presc_sel), .resync_delay(resync_delay),
    .ctr_reset(ctr_reset), .pwr_down(pwr_down), .pd_polarity(pd_polarity),
    .cp_code(cp_code), .resync_mult(resync_mult), .ns_mode(ns_mode),
    .chan_strobe(chan_strobe)
  );
endmodule

// File: tb/tb_synth_serial_regs.sv
module tb_synth_serial_regs;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_data = 1'b0, ser_le = 1'b0;
  logic [8:0] n_int; logic [11:0] n_frac; logic fastlock;
  logic [3:0] ref_count; logic [11:0] mod_active; logic [2:0] mux_sel;
  logic presc_sel; logic [11:0] resync_delay;
  logic ctr_reset, pwr_down, pd_polarity; logic [2:0] cp_code;
  logic [3:0] resync_mult; logic [1:0] ns_mode; logic chan_strobe;

  int vectors = 0, errors = 0, strobes = 0, stb_run = 0, stb_max = 0;
  bit done = 0;

  always #2 clk = ~clk;

  synth_serial_regs dut (.*);

  always @(posedge clk) begin
    if (chan_strobe) begin strobes++; stb_run++; end else stb_run = 0;
    if (stb_run > stb_max) stb_max = stb_run;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin errors++; $display("FAIL %s actual=%h expected=%h", tag, act, exp); end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bits(input logic [31:0] bits, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      ser_data = bits[i];
      wait_clk(4); ser_clk = 1'b1;
      wait_clk(4); ser_clk = 1'b0;
    end
  endtask

  task automatic pulse_le();
    wait_clk(4); ser_le = 1'b1; wait_clk(4); ser_le = 1'b0; wait_clk(6);
  endtask

  task automatic send(input logic [23:0] w);
    shift_bits({8'h0, w}, 24); pulse_le();
  endtask

  function automatic logic [23:0] w_n(input bit fl, input logic [8:0] iv, input logic [11:0] fr);
    return {fl, iv, fr, 2'b00};
  endfunction
  function automatic logic [23:0] w_r(input bit ld, input logic [2:0] mx, input bit ps,
                                      input logic [3:0] rc, input logic [11:0] md);
    return {ld, mx, ps, 1'b0, rc, md, 2'b01};
  endfunction
  function automatic logic [23:0] w_c(input logic [3:0] mu, input logic [2:0] cp, input bit pol,
                                      input bit pd, input bit cr);
    return {10'h0, mu, cp, pol, 1'b0, pd, cr, 1'b0, 2'b10};
  endfunction

  task automatic t_reset();
    chk(n_int == 0 && n_frac == 0 && mod_active == 0 && resync_delay == 0 && ref_count == 0 &&
        cp_code == 0 && pwr_down == 0 && ns_mode == 0 && chan_strobe == 0, "R11 reset",
        {n_int, n_frac, mod_active[10:0]}, 0);
  endtask

  task automatic t_ndiv();
    int s0 = strobes;
    send(w_n(1'b1, 9'd301, 12'h5A3));
    chk(n_int == 9'd301, "R3 n_int", n_int, 301);
    chk(n_frac == 12'h5A3, "R3 n_frac", n_frac, 12'h5A3);
    chk(fastlock == 1'b1, "R3 fastlock", fastlock, 1);
    chk(strobes == s0 + 1, "R9 one strobe per N write", strobes - s0, 1);
    chk(ref_count == 0 && cp_code == 0 && ns_mode == 0, "R2 others untouched", ref_count, 0);
  endtask

  task automatic t_rdiv_mod();
    int s0 = strobes;
    send(w_r(1'b0, 3'd5, 1'b1, 4'd13, 12'd65));
    chk(ref_count == 4'd13, "R4 ref_count", ref_count, 13);
    chk(mux_sel == 3'd5 && presc_sel == 1'b1, "R4 mux/presc", {mux_sel, presc_sel}, {3'd5, 1'b1});
    chk(mod_active == 12'd0, "R5 modulus still staged", mod_active, 0);
    chk(strobes == s0, "R9 no strobe on R write", strobes - s0, 0);
    chk(n_int == 9'd301, "R2 N untouched by R write", n_int, 301);
    send(w_n(1'b0, 9'd92, 12'd7));
    chk(mod_active == 12'd65, "R5 modulus promoted", mod_active, 65);
    chk(fastlock == 1'b0 && n_int == 9'd92, "R3 second N word", {fastlock, n_int}, {1'b0, 9'd92});
  endtask

  task automatic t_loadctl();
    send(w_r(1'b1, 3'd2, 1'b0, 4'd3, 12'd3900));
    chk(resync_delay == 12'd3900, "R6 resync delay", resync_delay, 3900);
    chk(ref_count == 4'd13 && mux_sel == 3'd5 && presc_sel == 1'b1, "R6 R fields kept",
        {ref_count, mux_sel, presc_sel}, {4'd13, 3'd5, 1'b1});
    send(w_n(1'b0, 9'd92, 12'd8));
    chk(mod_active == 12'd65, "R6 staged modulus kept", mod_active, 65);
  endtask

  task automatic t_ctrl_ns();
    send(w_c(4'd10, 3'd6, 1'b1, 1'b0, 1'b1));
    chk(resync_mult == 4'd10 && cp_code == 3'd6 && pd_polarity && ctr_reset && !pwr_down,
        "R7 control fields", {resync_mult, cp_code, pd_polarity, pwr_down, ctr_reset},
        {4'd10, 3'd6, 1'b1, 1'b0, 1'b1});
    send({20'h0, 2'b10, 2'b11});
    chk(ns_mode == 2'b10, "R8 noise mode", ns_mode, 2);
    chk(cp_code == 3'd6 && n_int == 9'd92, "R2 ns write isolated", {cp_code, n_int}, {3'd6, 9'd92});
  endtask

  task automatic t_powerdown();
    send(w_c(4'd1, 3'd2, 1'b0, 1'b1, 1'b0));
    chk(pwr_down == 1'b1, "R10 power-down set", pwr_down, 1);
    chk(n_frac == 12'd8 && mod_active == 12'd65 && ns_mode == 2'b10, "R10 contents kept",
        {n_frac, mod_active}, {12'd8, 12'd65});
    send(w_n(1'b0, 9'd200, 12'd44));
    chk(n_int == 9'd200 && n_frac == 12'd44, "R10 loads while powered down", n_int, 200);
  endtask

  task automatic t_overlong_noload();
    shift_bits(32'hFF, 8);
    shift_bits({8'h0, w_n(1'b1, 9'd77, 12'd9)}, 24);
    chk(n_int == 9'd200, "R12 no change without load", n_int, 200);
    pulse_le();
    chk(n_int == 9'd77 && n_frac == 12'd9 && fastlock, "R1 last 24 bits used",
        {fastlock, n_int, n_frac}, {1'b1, 9'd77, 12'd9});
    chk(stb_max == 1, "R9 strobe width", stb_max, 1);
  endtask

  initial begin
    fork
      begin
        wait_clk(3); rst_n = 1'b1; wait_clk(3);
        t_reset();
        t_ndiv();
        t_rdiv_mod();
        t_loadctl();
        t_ctrl_ns();
        t_powerdown();
        t_overlong_noload();
        done = 1;
      end
      begin
        repeat (150000) @(posedge clk);
        if (!done) begin vectors++; errors++; $display("FAIL watchdog actual=hung expected=done"); end
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule